// File: doc/BRIEF.md
# Tunable Numerically Controlled Oscillator

This block is the digital core of a direct digital synthesizer. A wide phase accumulator advances by a frequency tuning word on every clock. The output frequency is therefore the tuning word times the clock rate divided by two to the accumulator width. A run-time phase offset is added to the accumulated phase. Only the top bits of that sum are kept, and they address a quarter-wave sine table. The resulting signed sample is multiplied by an unsigned amplitude fraction and rounded back to the output width, ready for a DAC.

The tuning word, phase offset and amplitude are written through a single-cycle register port. When profile mode is selected, the tuning word comes instead from a table of preloaded tuning words, chosen by an index input. Stepping the index produces frequency hops or stepped chirps. None of these changes clears the accumulator, so every frequency change is phase-continuous.

Top module: `nco_core`

## Requirements
- R1: A synchronous active-low reset clears the accumulator, the tuning word and the offset, sets the amplitude to all ones (1023), and drives every pipeline stage and `sample_out` to 0.
- R2: On every clock out of reset, the 32-bit accumulator adds the effective tuning word and wraps modulo 2^32. No write and no profile change ever clears it.
- R3: A write (`cfg_we`=1) with `cfg_addr`=0 loads the tuning word from `cfg_wdata`. Address 1 loads the phase offset, and address 2 loads the amplitude from `cfg_wdata[9:0]`. The accumulator first uses a new tuning word on the clock after the write edge.
- R4: The phase word is bits [31:20] of (accumulator + offset) modulo 2^32. The low 20 bits are truncated, not rounded.
- R5: The sine stage maps phase word p to round(8191·sin(2π(p+0.5)/4096)), within one LSB. It does this from a 1024-entry quarter table: p[11] negates the sample, and p[10] mirrors the table address.
- R6: The output is floor((s·A + 512)/1024), within one LSB, where s is the sine sample and A is the 10-bit amplitude. An amplitude of 0 gives 0, and the output never reaches −8192.
- R7: The accumulator and offset held after clock edge t set `sample_out` after edge t+3. The amplitude held after edge t sets `sample_out` after edge t+1.
- R8: While `prof_en`=1, the effective tuning word is profile entry `prof_idx` (entry i held in `PROF_TUNE[32i+31:32i]`). The register tuning word is kept, can still be written, and is used again once `prof_en` returns to 0.
- R9: A write with `cfg_addr`=3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register select: 0 tuning, 1 offset, 2 amplitude |
| cfg_wdata | input | 32 | Write data |
| prof_en | input | 1 | Take the tuning word from the profile table |
| prof_idx | input | 2 | Profile entry index |
| sample_out | output | 14 | Signed scaled sine sample |

## Verification
The bench builds the block with its default widths: a 32-bit accumulator, a 12-bit phase word, a 14-bit output and a 10-bit amplitude. It overrides the profile table with four tuning words of its own. At these sizes every one of the 4096 phase words and all 1024 amplitude codes can be swept through the offset and amplitude registers, with the accumulator held at zero. A cycle model derived from the latency rule then follows tones that wrap the accumulator, mid-run frequency changes, profile hops and a reset during operation.

// File: rtl/nco_pkg.sv
// Package: shared register addresses and the elaboration-time sine
// generator for the oscillator. Assumes quarter tables of a power-of-two
// length; the generator uses only real arithmetic (no math library).
package nco_pkg;

    localparam logic [1:0] ADDR_TUNE = 2'd0;
    localparam logic [1:0] ADDR_OFFS = 2'd1;
    localparam logic [1:0] ADDR_AMP  = 2'd2;

    // Magnitude of entry idx of a quarter-wave table of qlen entries,
    // sampled at half-step centres and scaled to peak.
    function automatic int quarter_sine(input int idx, input int qlen, input int peak);
        real x;
        real term;
        real acc;
        x    = 2.0 * 3.14159265358979323846 * (real'(idx) + 0.5) / real'(4 * qlen);
        term = x;
        acc  = x;
        for (int k = 1; k < 14; k++) begin
            term = -term * x * x / real'((2 * k) * (2 * k + 1));
            acc  = acc + term;
        end
        return int'(real'(peak) * acc);
    endfunction

endpackage

// File: rtl/nco_cfg_regs.sv
// Configuration registers: tuning word, phase offset, amplitude.
// Assumes a single-cycle write strobe; unknown addresses are ignored.
module nco_cfg_regs #(
    parameter int ACC_W = 32,
    parameter int AMP_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [1:0]       addr,
    input  logic [ACC_W-1:0] wdata,
    output logic [ACC_W-1:0] tune_q,
    output logic [ACC_W-1:0] offs_q,
    output logic [AMP_W-1:0] amp_q
);
    import nco_pkg::*;

    // Capture register writes; reset to zero tuning/offset and full amplitude.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tune_q <= '0;
            offs_q <= '0;
            amp_q  <= '1;
        end else if (we) begin
            case (addr)
                ADDR_TUNE: tune_q <= wdata;
                ADDR_OFFS: offs_q <= wdata;
                ADDR_AMP:  amp_q  <= wdata[AMP_W-1:0];
                default:   ;
            endcase
        end
    end
endmodule

// File: rtl/nco_phase_acc.sv
// Phase accumulator plus offset-and-truncate stage. The accumulator wraps
// modulo 2^ACC_W; the phase word keeps the top PHASE_W bits of the sum.
module nco_phase_acc #(
    parameter int ACC_W   = 32,
    parameter int PHASE_W = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ACC_W-1:0]   tune,
    input  logic [ACC_W-1:0]   offs,
    output logic [ACC_W-1:0]   acc_q,
    output logic [PHASE_W-1:0] ph_q
);
    localparam int DROP = ACC_W - PHASE_W;

    // Advance the accumulator by the effective tuning word.
    always_ff @(posedge clk) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_q + tune;
    end

    // Add the offset and keep only the upper phase bits.
    always_ff @(posedge clk) begin
        if (!rst_n) ph_q <= '0;
        else        ph_q <= PHASE_W'((acc_q + offs) >> DROP);
    end
endmodule

// File: rtl/nco_sine_lut.sv
// Quarter-wave sine lookup. Top phase bit negates, next bit mirrors the
// table address. Table contents are computed at elaboration.
module nco_sine_lut #(
    parameter int PHASE_W = 12,
    parameter int OUT_W   = 14
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [PHASE_W-1:0]      ph,
    output logic signed [OUT_W-1:0] sine_q
);
    localparam int QLEN  = 2 ** (PHASE_W - 2);
    localparam int MAG_W = OUT_W - 1;
    localparam int PEAK  = 2 ** (OUT_W - 1) - 1;

    logic [MAG_W-1:0]        rom [QLEN];
    logic [PHASE_W-3:0]      idx;
    logic signed [OUT_W-1:0] mag_s;

    for (genvar i = 0; i < QLEN; i++) begin : g_rom
        localparam logic [MAG_W-1:0] V = MAG_W'(nco_pkg::quarter_sine(i, QLEN, PEAK));
        assign rom[i] = V;
    end

    // Mirror the address in odd quadrants and fetch the magnitude.
    always_comb begin
        idx   = ph[PHASE_W-2] ? ~ph[PHASE_W-3:0] : ph[PHASE_W-3:0];
        mag_s = $signed({1'b0, rom[idx]});
    end

    // Register the signed sample, negated in the lower half-cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) sine_q <= '0;
        else        sine_q <= ph[PHASE_W-1] ? -mag_s : mag_s;
    end
endmodule

// File: rtl/nco_amp_scale.sv
// Amplitude scaler: multiplies by an unsigned AMP_W-bit fraction of 2^AMP_W
// and rounds half-up. Assumes |sample| <= 2^(OUT_W-1)-1, so no overflow.
module nco_amp_scale #(
    parameter int OUT_W = 14,
    parameter int AMP_W = 10
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic signed [OUT_W-1:0] sample,
    input  logic [AMP_W-1:0]        amp,
    output logic signed [OUT_W-1:0] out_q
);
    localparam int PW = OUT_W + AMP_W + 1;

    logic signed [PW-1:0] prod;
    logic signed [PW-1:0] rnd;

    // Form the full product and add the rounding half.
    always_comb begin
        prod = PW'(sample) * PW'($signed({1'b0, amp}));
        rnd  = prod + $signed(PW'(1 << (AMP_W - 1)));
    end

    // Drop the fraction bits into the output register.
    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= OUT_W'(rnd >>> AMP_W);
    end
endmodule

// File: rtl/nco_core.sv
// Top of the oscillator: register port, profile selection, accumulator,
// lookup and amplitude scaling. Latency from accumulator to output is 3.
module nco_core #(
    parameter int ACC_W    = 32,
    parameter int PHASE_W  = 12,
    parameter int OUT_W    = 14,
    parameter int AMP_W    = 10,
    parameter int NUM_PROF = 4,
    parameter int PROF_IW  = 2,
    parameter logic [NUM_PROF*ACC_W-1:0] PROF_TUNE =
        {32'h0800_0000, 32'h0400_0000, 32'h0200_0000, 32'h0100_0000}
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cfg_we,
    input  logic [1:0]              cfg_addr,
    input  logic [ACC_W-1:0]        cfg_wdata,
    input  logic                    prof_en,
    input  logic [PROF_IW-1:0]      prof_idx,
    output logic signed [OUT_W-1:0] sample_out
);
    logic [ACC_W-1:0]        tune_q;
    logic [ACC_W-1:0]        offs_q;
    logic [AMP_W-1:0]        amp_q;
    logic [ACC_W-1:0]        tune_sel;
    logic [ACC_W-1:0]        acc_q;
    logic [PHASE_W-1:0]      ph_q;
    logic signed [OUT_W-1:0] sine_q;

    nco_cfg_regs #(.ACC_W(ACC_W), .AMP_W(AMP_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr),
        .wdata(cfg_wdata), .tune_q(tune_q), .offs_q(offs_q), .amp_q(amp_q)
    );

    // Pick the tuning word from the profile table or the register.
    always_comb begin
        tune_sel = prof_en ? PROF_TUNE[prof_idx * ACC_W +: ACC_W] : tune_q;
    end

    nco_phase_acc #(.ACC_W(ACC_W), .PHASE_W(PHASE_W)) u_acc (
        .clk(clk), .rst_n(rst_n), .tune(tune_sel), .offs(offs_q),
        .acc_q(acc_q), .ph_q(ph_q)
    );

    nco_sine_lut #(.PHASE_W(PHASE_W), .OUT_W(OUT_W)) u_lut (
        .clk(clk), .rst_n(rst_n), .ph(ph_q), .sine_q(sine_q)
    );

    nco_amp_scale #(.OUT_W(OUT_W), .AMP_W(AMP_W)) u_scale (
        .clk(clk), .rst_n(rst_n), .sample(sine_q), .amp(amp_q), .out_q(sample_out)
    );
endmodule

// File: rtl/nco_core_chk.sv
// Checker for nco_core: reset clearing, muting, quadrant sign and the
// output range. Attached to every nco_core by the bind below.
module nco_core_chk #(
    parameter int PHASE_W = 12,
    parameter int OUT_W   = 14,
    parameter int AMP_W   = 10
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [AMP_W-1:0]        amp,
    input logic [PHASE_W-1:0]      ph,
    input logic signed [OUT_W-1:0] sine,
    input logic signed [OUT_W-1:0] sample_out
);
    logic rst_seen;

    // Remember whether the previous edge was a reset edge.
    always_ff @(posedge clk) rst_seen <= !rst_n;

    // R1: after a reset edge the output is zero.
    always @(posedge clk) begin
        if (rst_seen === 1'b1)
            assert_reset_clear_R1: assert (sample_out == '0);
    end

    assert_mute_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (amp == '0) |=> (sample_out == '0));

    assert_neg_half_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ph[PHASE_W-1] |=> (sine <= 0));

    assert_pos_half_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !ph[PHASE_W-1] |=> (sine >= 0));

    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sample_out != {1'b1, {(OUT_W-1){1'b0}}});
endmodule

bind nco_core nco_core_chk #(.PHASE_W(PHASE_W), .OUT_W(OUT_W), .AMP_W(AMP_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .amp(amp_q), .ph(ph_q), .sine(sine_q),
    .sample_out(sample_out)
);

// File: tb/sim_nco_core.sv
// Bench: a cycle model built from the requirements is compared with the
// output on every falling edge; directed phases sweep phase and amplitude.
module sim_nco_core;
    localparam int CLK_PERIOD = 10;
    localparam logic [127:0] PROFS =
        {32'h0000_1000, 32'hF000_0000, 32'h1999_999A, 32'h0A3D_70A4};

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               cfg_we = 1'b0;
    logic [1:0]         cfg_addr = 2'd0;
    logic [31:0]        cfg_wdata = '0;
    logic               prof_en = 1'b0;
    logic [1:0]         prof_idx = 2'd0;
    logic signed [13:0] sample_out;

    int    n_vec = 0;
    int    n_fail = 0;
    bit    chk_en = 1'b0;
    bit    done = 1'b0;
    string cur_req = "R1";

    // Model state
    logic [31:0] m_acc = '0, m_ftw = '0, m_off = '0;
    logic [9:0]  m_amp = '1;
    logic [11:0] m_ph = '0;
    int          m_s = 0;
    int          m_out = 0;

    nco_core #(.PROF_TUNE(PROFS)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .prof_en(prof_en), .prof_idx(prof_idx),
        .sample_out(sample_out)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic int exp_sine(input logic [11:0] p);
        return int'(8191.0 * $sin(2.0 * 3.14159265358979323846 * (real'(p) + 0.5) / 4096.0));
    endfunction

    function automatic int exp_scale(input int s, input logic [9:0] a);
        return (s * int'(a) + 512) >>> 10;
    endfunction

    // Requirement model, updated at the same edges as the design.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_acc <= '0; m_ftw <= '0; m_off <= '0; m_amp <= '1;
            m_ph <= '0; m_s <= 0; m_out <= 0;
            chk_en <= 1'b1;
        end else begin
            m_acc <= m_acc + (prof_en ? PROFS[prof_idx * 32 +: 32] : m_ftw);
            m_ph  <= 12'((m_acc + m_off) >> 20);
            m_s   <= exp_sine(m_ph);
            m_out <= exp_scale(m_s, m_amp);
            if (cfg_we) begin
                case (cfg_addr)
                    2'd0: m_ftw <= cfg_wdata;
                    2'd1: m_off <= cfg_wdata;
                    2'd2: m_amp <= cfg_wdata[9:0];
                    default: ;
                endcase
            end
        end
    end

    // Compare away from the active edge.
    always @(negedge clk) begin
        if (chk_en && !done) begin
            int d;
            n_vec++;
            d = int'(sample_out) - m_out;
            if (d > 1 || d < -1) begin
                n_fail++;
                $display("FAIL %s: sample_out=%0d expected=%0d", cur_req, sample_out, m_out);
            end
        end
    end

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    initial begin
        // R1: reset state
        step(3);
        rst_n = 1'b1;
        step(4);

        // R4 R5 R7: sweep every phase word through the offset register
        cur_req = "R4/R5";
        for (int p = 0; p < 4096; p++) begin
            @(negedge clk);
            cfg_we = 1'b1; cfg_addr = 2'd1;
            cfg_wdata = {p[11:0], (p % 2 == 1) ? 20'hFFFFF : 20'h00000};
        end
        @(negedge clk); cfg_we = 1'b0;
        step(4);

        // R6 R7: all amplitude codes at the positive and negative peaks
        cur_req = "R6";
        for (int k = 0; k < 2; k++) begin
            wr(2'd1, (k == 0) ? 32'h4000_0000 : 32'hC000_0000);
            for (int a = 0; a < 1024; a++) begin
                @(negedge clk);
                cfg_we = 1'b1; cfg_addr = 2'd2; cfg_wdata = 32'(a);
                if (sample_out == -14'sd8192) begin
                    n_fail++;
                    $display("FAIL R6: sample_out=%0d expected>-8192", sample_out);
                end
                n_vec++;
            end
            @(negedge clk); cfg_we = 1'b0;
            step(4);
        end
        wr(2'd2, 32'd1023);
        wr(2'd1, 32'd0);

        // R2 R3: tones, wrapping and phase-continuous tuning changes
        cur_req = "R2/R3";
        wr(2'd0, 32'h0010_0000); step(300);
        wr(2'd0, 32'h0123_4567); step(300);
        wr(2'd0, 32'hFFF0_0000); step(300);
        wr(2'd0, 32'h8000_0001); step(100);
        wr(2'd1, 32'h3000_0000); step(100);
        wr(2'd2, 32'd300);       step(100);

        // R9: address 3 writes change nothing
        cur_req = "R9";
        wr(2'd3, 32'hDEAD_BEEF); step(50);

        // R8: profile hops, register tuning retained and updated meanwhile
        cur_req = "R8";
        prof_en = 1'b1;
        for (int i = 0; i < 4; i++) begin
            prof_idx = 2'(i);
            step(100);
        end
        wr(2'd0, 32'h0203_0405); step(50);
        prof_en = 1'b0; step(100);

        // R1: reset in the middle of a run
        cur_req = "R1";
        rst_n = 1'b0; step(3);
        rst_n = 1'b1; step(20);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog: run=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end
endmodule